// File: doc/BRIEF.md
# Alter/Skip Accumulator Micro-Operation Unit

This unit executes one alter/skip word of a small 16-bit processor in a single clock. The word names one of the two accumulators and carries a set of micro-operations. They alter the chosen accumulator and the extend bit, increment the accumulator, and test the extend bit and the accumulator's sign, low bit and zero state. These operations run in a fixed order. The unit returns the updated accumulators, extend and overflow, together with a skip decision. The sequencer uses that decision to advance the program counter by one extra word.

The caller places the word, both accumulators and both flag bits on the inputs and pulses `strobe_i`. On the next clock edge all results appear on the outputs. A word from another instruction group is not executed: the register outputs copy the inputs unchanged and no skip is reported.

Top module: `alter_skip_unit`

## Requirements
- R1: A word executes only when bits 15:12 are 0000 and bit 10 is 1. Bit 11 picks the accumulator: 0 selects A, 1 selects B. The other accumulator is passed through unchanged. Any other word gives done_o=0 and skip_o=0, and the register outputs copy acc_a_i, acc_b_i, ext_i and ovf_i.
- R2: Bits 9:8 act on the selected accumulator before every other operation: 00 leaves it, 01 clears it, 10 takes its one's complement, 11 sets it to all ones.
- R3: Bits 7:6 act on extend: 00 leaves it, 01 clears it, 10 complements it, 11 sets it. The extend test (bit 5) uses the extend value from before this alteration.
- R4: Bit 5 tests extend==0. Bit 4 tests sign bit==0 and bit 3 tests bit 0==0, both on the value after the accumulator alteration and before the increment. Bit 1 tests the final value (after the increment) for zero.
- R5: When bit 0 is clear, the skip is taken if any requested test is true. With no test requested there is no skip.
- R6: When bit 0 is set, each test checks the opposite condition. A word with bit 0 set and no test bits set (5, 4, 3, 1) always skips.
- R7: When bit 0 is set and both bit 4 and bit 3 are set, the sign and low-bit tests combine with AND: both bits must be 1. That result then ORs with the other tests.
- R8: Bit 2 increments the accumulator after the extend alteration. A carry out of the top bit sets extend. Without a carry, extend keeps its altered value and is never toggled.
- R9: An increment from 0x7FFF to 0x8000 sets overflow. Overflow is sticky: a set ovf_i always gives ovf_o=1.
- R10: Results appear on the clock edge at which strobe_i is sampled high, with done_o=1 for that one cycle. When strobe_i is low, done_o and skip_o are 0 and the register outputs hold.
- R11: While reset is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Execute the word on the inputs |
| instr_i | input | 16 | Instruction word |
| acc_a_i | input | 16 | Accumulator A |
| acc_b_i | input | 16 | Accumulator B |
| ext_i | input | 1 | Extend bit |
| ovf_i | input | 1 | Overflow bit |
| acc_a_o | output | 16 | Updated accumulator A |
| acc_b_o | output | 16 | Updated accumulator B |
| ext_o | output | 1 | Updated extend bit |
| ovf_o | output | 1 | Updated overflow bit |
| skip_o | output | 1 | Skip the next word |
| done_o | output | 1 | A group word was executed |

## Verification
The assertions check several rules on every cycle:
- a word from another group passes through, and the unselected accumulator stays as it was;
- overflow stays set once set;
- extend is never cleared when there is no extend alteration;
- a bare reverse word always skips;
- outputs hold between strobes.

The ordering rules can only be shown by the bench's scenarios, because each one depends on a specific data value. These are:
- the extend test seeing the extend value from before its alteration;
- the sign and low-bit tests seeing the value before the increment;
- the zero test seeing the value after it;
- the AND pairing under reverse;
- the 0x7FFF and 0xFFFF increment edges.

// File: rtl/asg_pkg.sv
package asg_pkg;
  localparam int INSTR_W = 16;

  typedef enum logic [1:0] {
    ALT_NOP = 2'b00,
    ALT_CLR = 2'b01,
    ALT_CMP = 2'b10,
    ALT_SET = 2'b11
  } alt_e;

  typedef struct packed {
    logic sel_b;
    alt_e acc_alt;
    alt_e ext_alt;
    logic t_ext;
    logic t_sign;
    logic t_lsb;
    logic inc;
    logic t_zero;
    logic rev;
  } asg_ctl_t;

  function automatic logic is_group(input logic [INSTR_W-1:0] w);
    return (w[15:12] == 4'b0000) && w[10];
  endfunction

  function automatic asg_ctl_t decode(input logic [INSTR_W-1:0] w);
    asg_ctl_t c;
    c.sel_b   = w[11];
    c.acc_alt = alt_e'(w[9:8]);
    c.ext_alt = alt_e'(w[7:6]);
    c.t_ext   = w[5];
    c.t_sign  = w[4];
    c.t_lsb   = w[3];
    c.inc     = w[2];
    c.t_zero  = w[1];
    c.rev     = w[0];
    return c;
  endfunction
endpackage

// File: rtl/asg_alter.sv
module asg_alter
  import asg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic              ext_i,
  input  logic              ovf_i,
  input  alt_e              acc_alt_i,
  input  alt_e              ext_alt_i,
  input  logic              inc_i,
  output logic [DATA_W-1:0] mid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              ext_o,
  output logic              ovf_o
);
  logic              ext_mid;
  logic              carry;
  logic [DATA_W-1:0] sum;

  always_comb begin
    unique case (acc_alt_i)
      ALT_CLR: mid_o = '0;
      ALT_CMP: mid_o = ~acc_i;
      ALT_SET: mid_o = '1;
      default: mid_o = acc_i;
    endcase
  end

  always_comb begin
    unique case (ext_alt_i)
      ALT_CLR: ext_mid = 1'b0;
      ALT_CMP: ext_mid = ~ext_i;
      ALT_SET: ext_mid = 1'b1;
      default: ext_mid = ext_i;
    endcase
  end

  assign {carry, sum} = {1'b0, mid_o} + {{DATA_W{1'b0}}, 1'b1};

  always_comb begin
    res_o = inc_i ? sum : mid_o;
    // carry only sets extend, never toggles it
    ext_o = ext_mid | (inc_i & carry);
    ovf_o = ovf_i | (inc_i & ~mid_o[DATA_W-1] & sum[DATA_W-1]);
  end
endmodule

// File: rtl/asg_skip.sv
module asg_skip #(
  parameter int DATA_W = 16
) (
  input  logic              ext_pre_i,
  input  logic [DATA_W-1:0] mid_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              t_ext_i,
  input  logic              t_sign_i,
  input  logic              t_lsb_i,
  input  logic              t_zero_i,
  input  logic              rev_i,
  output logic              skip_o
);
  localparam int NT = 4;
  localparam int IX_EXT = 0, IX_SGN = 1, IX_LSB = 2, IX_ZRO = 3;

  logic [NT-1:0] en, is_zero, hit;
  logic          pair;

  assign en      = {t_zero_i, t_lsb_i, t_sign_i, t_ext_i};
  assign is_zero = {(res_i == '0), ~mid_i[0], ~mid_i[DATA_W-1], ~ext_pre_i};

  for (genvar i = 0; i < NT; i++) begin : g_test
    assign hit[i] = en[i] & (is_zero[i] ^ rev_i);
  end

  always_comb begin
    if (rev_i && en[IX_SGN] && en[IX_LSB]) pair = hit[IX_SGN] & hit[IX_LSB];
    else                                   pair = hit[IX_SGN] | hit[IX_LSB];
    skip_o = hit[IX_EXT] | pair | hit[IX_ZRO] | (rev_i & ~(|en));
  end
endmodule

// File: rtl/alter_skip_unit.sv
module alter_skip_unit
  import asg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [15:0]       instr_i,
  input  logic [DATA_W-1:0] acc_a_i,
  input  logic [DATA_W-1:0] acc_b_i,
  input  logic              ext_i,
  input  logic              ovf_i,
  output logic [DATA_W-1:0] acc_a_o,
  output logic [DATA_W-1:0] acc_b_o,
  output logic              ext_o,
  output logic              ovf_o,
  output logic              skip_o,
  output logic              done_o
);
  asg_ctl_t          ctl;
  logic              grp;
  logic [DATA_W-1:0] acc_sel, mid, res;
  logic              ext_nx, ovf_nx, skip_nx;

  assign grp     = is_group(instr_i);
  assign ctl     = decode(instr_i);
  assign acc_sel = ctl.sel_b ? acc_b_i : acc_a_i;

  asg_alter #(.DATA_W(DATA_W)) u_alter (
    .acc_i    (acc_sel),
    .ext_i    (ext_i),
    .ovf_i    (ovf_i),
    .acc_alt_i(ctl.acc_alt),
    .ext_alt_i(ctl.ext_alt),
    .inc_i    (ctl.inc),
    .mid_o    (mid),
    .res_o    (res),
    .ext_o    (ext_nx),
    .ovf_o    (ovf_nx)
  );

  asg_skip #(.DATA_W(DATA_W)) u_skip (
    .ext_pre_i(ext_i),
    .mid_i    (mid),
    .res_i    (res),
    .t_ext_i  (ctl.t_ext),
    .t_sign_i (ctl.t_sign),
    .t_lsb_i  (ctl.t_lsb),
    .t_zero_i (ctl.t_zero),
    .rev_i    (ctl.rev),
    .skip_o   (skip_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_a_o <= '0;
      acc_b_o <= '0;
      ext_o   <= 1'b0;
      ovf_o   <= 1'b0;
      skip_o  <= 1'b0;
      done_o  <= 1'b0;
    end else if (strobe_i) begin
      done_o  <= grp;
      skip_o  <= grp & skip_nx;
      ext_o   <= grp ? ext_nx : ext_i;
      ovf_o   <= grp ? ovf_nx : ovf_i;
      acc_a_o <= (grp && !ctl.sel_b) ? res : acc_a_i;
      acc_b_o <= (grp &&  ctl.sel_b) ? res : acc_b_i;
    end else begin
      done_o <= 1'b0;
      skip_o <= 1'b0;
    end
  end

  // R1
  foreign_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !grp |=> !done_o && !skip_o && acc_a_o == $past(acc_a_i)
                         && acc_b_o == $past(acc_b_i) && ext_o == $past(ext_i));
  // R1
  unsel_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && grp |=> ($past(instr_i[11]) ? acc_a_o == $past(acc_a_i)
                                            : acc_b_o == $past(acc_b_i)));
  // R6
  bare_rev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && grp && instr_i[5:0] == 6'b000001 && instr_i[4:3] == 2'b00 |=> skip_o);
  // R8
  ext_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && grp && instr_i[7:6] == 2'b00 && ext_i |=> ext_o);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && ovf_i |=> ovf_o);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !done_o && !skip_o && $stable(acc_a_o) && $stable(acc_b_o)
                  && $stable(ext_o) && $stable(ovf_o));
endmodule

// File: tb/sim_alter_skip_unit.sv
module sim_alter_skip_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0, rst_n = 1'b0, strobe = 1'b0;
  logic [15:0]  instr = '0;
  logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
  logic         e_in = 1'b0, v_in = 1'b0, e_out, v_out, skip, done;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alter_skip_unit #(.DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .instr_i(instr),
    .acc_a_i(a_in), .acc_b_i(b_in), .ext_i(e_in), .ovf_i(v_in),
    .acc_a_o(a_out), .acc_b_o(b_out), .ext_o(e_out), .ovf_o(v_out),
    .skip_o(skip), .done_o(done));

  // {done, skip, ovf, ext, a, b}
  function automatic logic [35:0] model(input logic [15:0] w, input logic [15:0] a,
                                        input logic [15:0] b, input logic e, input logic v);
    logic [15:0] x;
    logic        en, sk, ts, tl, any;
    if (!(w[15:12] == 4'd0 && w[10])) return {2'b00, v, e, a, b};
    x  = w[11] ? b : a;
    en = e;
    case (w[9:8]) 2'd1: x = 16'h0; 2'd2: x = ~x; 2'd3: x = 16'hFFFF; default: ; endcase
    sk = w[5] && ((e == 1'b0) ^ w[0]);
    case (w[7:6]) 2'd1: en = 1'b0; 2'd2: en = ~en; 2'd3: en = 1'b1; default: ; endcase
    ts = w[4] && ((x[15] == 1'b0) ^ w[0]);
    tl = w[3] && ((x[0] == 1'b0) ^ w[0]);
    if (w[0] && w[4] && w[3]) sk = sk || (ts && tl);
    else sk = sk || ts || tl;
    if (w[2]) begin
      if (x == 16'h7FFF) v = 1'b1;
      if (x == 16'hFFFF) en = 1'b1;
      x = x + 16'd1;
    end
    if (w[1] && ((x == 16'h0) ^ w[0])) sk = 1'b1;
    any = w[5] | w[4] | w[3] | w[1];
    if (w[0] && !any) sk = 1'b1;
    return {1'b1, sk, v, en, w[11] ? a : x, w[11] ? x : b};
  endfunction

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s instr=%h got=%h exp=%h", tag, instr, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [15:0] w, input logic [15:0] a,
                     input logic [15:0] b, input logic e, input logic v);
    @(negedge clk);
    instr = w; a_in = a; b_in = b; e_in = e; v_in = v; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    check(tag, {done, skip, v_out, e_out, a_out, b_out}, model(w, a, b, e, v));
  endtask

  initial begin
    logic [35:0] held;
    logic [15:0] w;
    void'($urandom(32'd1957));
    #(3*CLK_PERIOD + 2);
    check("R11", {done, skip, v_out, e_out, a_out, b_out}, 36'h0);
    rst_n = 1'b1;
    // R1: foreign group, B selection
    run("R1", 16'h1000 | 16'h0400 | 16'h0004, 16'h1234, 16'h5678, 1'b1, 1'b0);
    run("R1", 16'h0000 | 16'h0004, 16'h1234, 16'h5678, 1'b0, 1'b1);
    run("R1", 16'h0C04, 16'h1111, 16'h2222, 1'b0, 1'b0);
    // R2
    run("R2", 16'h0500, 16'hABCD, 16'h0, 1'b0, 1'b0);
    run("R2", 16'h0600, 16'hABCD, 16'h0, 1'b0, 1'b0);
    run("R2", 16'h0700, 16'hABCD, 16'h0, 1'b0, 1'b0);
    // R3: extend alter and test on pre-alter extend
    run("R3", 16'h0460, 16'h0, 16'h0, 1'b0, 1'b0);
    run("R3", 16'h04A0, 16'h0, 16'h0, 1'b1, 1'b0);
    run("R3", 16'h04C0, 16'h0, 16'h0, 1'b0, 1'b0);
    // R4: sign/lsb before increment, zero after
    run("R4", 16'h0414, 16'h7FFF, 16'h0, 1'b0, 1'b0);
    run("R4", 16'h040C, 16'h0002, 16'h0, 1'b0, 1'b0);
    run("R4", 16'h0406, 16'hFFFF, 16'h0, 1'b0, 1'b0);
    run("R4", 16'h0402, 16'hFFFF, 16'h0, 1'b0, 1'b0);
    // R5
    run("R5", 16'h0418, 16'h8000, 16'h0, 1'b0, 1'b0);
    run("R5", 16'h0418, 16'h8001, 16'h0, 1'b0, 1'b0);
    run("R5", 16'h0400, 16'h0000, 16'h0, 1'b0, 1'b0);
    // R6
    run("R6", 16'h0401, 16'h0, 16'h0, 1'b0, 1'b0);
    run("R6", 16'h0423, 16'h0, 16'h0, 1'b0, 1'b0);
    run("R6", 16'h0423, 16'h5, 16'h0, 1'b0, 1'b0);
    // R7
    run("R7", 16'h0419, 16'h8000, 16'h0, 1'b0, 1'b0);
    run("R7", 16'h0419, 16'h8001, 16'h0, 1'b0, 1'b0);
    run("R7", 16'h0439, 16'h8000, 16'h0, 1'b0, 1'b0);
    // R8
    run("R8", 16'h0404, 16'hFFFF, 16'h0, 1'b0, 1'b0);
    run("R8", 16'h0404, 16'hFFFF, 16'h0, 1'b1, 1'b0);
    run("R8", 16'h0444, 16'hFFFF, 16'h0, 1'b1, 1'b0);
    run("R8", 16'h0404, 16'h0010, 16'h0, 1'b1, 1'b0);
    // R9
    run("R9", 16'h0404, 16'h7FFF, 16'h0, 1'b0, 1'b0);
    run("R9", 16'h0C04, 16'h0, 16'h7FFF, 1'b0, 1'b0);
    run("R9", 16'h0404, 16'h0001, 16'h0, 1'b0, 1'b1);
    // R10: hold without strobe
    run("R10", 16'h0707, 16'h1, 16'h2, 1'b1, 1'b0);
    held = {1'b0, 1'b0, v_out, e_out, a_out, b_out};
    instr = 16'h0400; a_in = 16'h9999; b_in = 16'h8888; e_in = 1'b0; v_in = 1'b1;
    @(negedge clk);
    check("R10", {done, skip, v_out, e_out, a_out, b_out}, held);
    // random
    for (int i = 0; i < 3000; i++) begin
      w = 16'($urandom);
      if ($urandom_range(3) != 0) begin w[15:12] = 4'd0; w[10] = 1'b1; end
      run("R5", w, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
    end
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog got=timeout exp=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule